// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a simple integer datapath. Each cycle it takes a 4-bit operation code and two operands, A and B. It produces a result word, a write-enable for that result, and the next value of a four-bit condition-flag set. A flag register inside the block holds the current flags. Its carry bit is the carry-in for the carry-chained operations, so a wide number can be added or subtracted one word at a time. The low words go first with flags enabled, then the upper words use the carry-chained codes.

The sixteen codes cover:
- copying B, or its bitwise inverse, to the result;
- add, subtract and reverse subtract, each with and without the stored carry;
- AND, XOR, OR and bit-clear;
- four compare/test codes that update the flags and leave the result unwritten.

Non-compare codes touch the flags only when the set-flags input is high. Flag vectors are packed as {N, Z, C, V}, so N sits in bit 3 and V in bit 0.

Top module: `dp_alu`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and on the first cycle after it, the stored flags `flags_o` read 4'b0000.
- R2: Code 4'hD (copy) gives result = B. Code 4'hF (copy-inverted) gives result = ~B. Both assert `result_we_o`.
- R3: Code 4'h4 gives A + B. Code 4'h2 gives A - B. Code 4'h3 gives B - A. All are taken modulo 2^WIDTH and all assert `result_we_o`.
- R4: The carry-chained codes use the stored C flag (`flags_o[1]`). Code 4'h5 gives A + B + C. Code 4'h6 gives A - B + C - 1. Code 4'h7 gives B - A + C - 1.
- R5: The bitwise codes assert `result_we_o` and give:
  - 4'h0: A & B
  - 4'h1: A ^ B
  - 4'hC: A | B
  - 4'hE: A & ~B, so every set bit of B clears the same result bit
- R6: Codes 4'h8 (test, A & B), 4'h9 (test-equal, A ^ B), 4'hA (compare, A - B) and 4'hB (compare-negative, A + B) never assert `result_we_o`. They always load their flags into `flags_o` at the next clock edge, whatever `set_flags_i` is.
- R7: For all other codes, `flags_o` takes `flags_nxt_o` at the clock edge only when `set_flags_i` is 1. Otherwise the flags keep their value.
- R8: When flags are updated, N is the top bit of the computed value, and Z is 1 exactly when every bit of the computed value is 0.
- R9: When flags are updated, C is set as follows:
  - add-type codes (4'h4, 4'h5, 4'hB): C is the carry out of the top bit;
  - subtract-type codes (4'h2, 4'h3, 4'h6, 4'h7, 4'hA): C is 1 when no borrow occurs; for plain subtract and compare this means unsigned A >= B.
- R10: When flags are updated, V is set as follows:
  - add and subtract codes: V is 1 on two's-complement signed overflow;
  - bitwise, copy and test codes: C and V keep their stored values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| set_flags_i | input | 1 | Allow a non-compare code to update the flags |
| result_o | output | WIDTH | Computed value |
| result_we_o | output | 1 | Result should be written back |
| flags_nxt_o | output | 4 | Flags that the next clock edge will store, {N,Z,C,V} |
| flags_o | output | 4 | Stored flags, {N,Z,C,V} |

## Verification
The bench builds the block with the default WIDTH of 32. This places the sign, carry and overflow boundaries at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and a 64-bit add or subtract is exercised as two chained 32-bit steps. At this width a 64-bit integer reference model computes exact sums and differences, so the reference derives carry, borrow and overflow from plain range tests rather than from an adder. Directed cases cover each flag edge; a long random run mixes codes, operands and the set-flags bit with whatever carry the previous step left.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

    function automatic logic op_is_compare(input alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_arith(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_RSB) || (op == OP_ADD) || (op == OP_ADC) ||
               (op == OP_SBC) || (op == OP_RSC) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x_d;
    logic [WIDTH-1:0] y_d;
    logic             cin_d;
    logic [WIDTH:0]   wide_d;

    // Every variant is x + y + cin on one adder; subtraction inverts the
    // subtrahend, reverse forms swap which operand is inverted.
    always_comb begin
        x_d   = a_i;
        y_d   = b_i;
        cin_d = 1'b0;
        unique case (op_i)
            OP_SUB, OP_CMP: begin x_d = a_i; y_d = ~b_i; cin_d = 1'b1;    end
            OP_RSB:         begin x_d = b_i; y_d = ~a_i; cin_d = 1'b1;    end
            OP_ADD, OP_CMN: begin x_d = a_i; y_d = b_i;  cin_d = 1'b0;    end
            OP_ADC:         begin x_d = a_i; y_d = b_i;  cin_d = carry_i; end
            OP_SBC:         begin x_d = a_i; y_d = ~b_i; cin_d = carry_i; end
            OP_RSC:         begin x_d = b_i; y_d = ~a_i; cin_d = carry_i; end
            default:        begin x_d = a_i; y_d = b_i;  cin_d = 1'b0;    end
        endcase
    end

    assign wide_d  = {1'b0, x_d} + {1'b0, y_d} + {{WIDTH{1'b0}}, cin_d};
    assign sum_o   = wide_d[MSB:0];
    assign carry_o = wide_d[WIDTH];
    assign ovf_o   = (x_d[MSB] == y_d[MSB]) && (wide_d[MSB] != x_d[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (op_i)
                OP_AND, OP_TST: res_o[i] = a_i[i] & b_i[i];
                OP_EOR, OP_TEQ: res_o[i] = a_i[i] ^ b_i[i];
                OP_ORR:         res_o[i] = a_i[i] | b_i[i];
                OP_BIC:         res_o[i] = a_i[i] & ~b_i[i];
                OP_MOV:         res_o[i] = b_i[i];
                OP_MVN:         res_o[i] = ~b_i[i];
                default:        res_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             set_flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             result_we_o,
    output logic [3:0]       flags_nxt_o,
    output logic [3:0]       flags_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        alu_flags_t flags;
    } state_t;

    alu_op_e          op;
    state_t           state_d;
    state_t           state_q;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_cout;
    logic             arith_ovf;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] value_d;
    logic             is_cmp_d;
    logic             is_arith_d;
    logic             update_d;

    assign op = alu_op_e'(op_i);

    dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op_i    (op),
        .a_i     (a_i),
        .b_i     (b_i),
        .carry_i (state_q.flags.c),
        .sum_o   (arith_sum),
        .carry_o (arith_cout),
        .ovf_o   (arith_ovf)
    );

    dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (logic_res)
    );

    always_comb begin
        is_cmp_d   = op_is_compare(op);
        is_arith_d = op_is_arith(op);
        update_d   = is_cmp_d || set_flags_i;
        value_d    = is_arith_d ? arith_sum : logic_res;
        state_d    = state_q;
        if (update_d) begin
            state_d.flags.n = value_d[MSB];
            state_d.flags.z = (value_d == '0);
            if (is_arith_d) begin
                state_d.flags.c = arith_cout;
                state_d.flags.v = arith_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o    = value_d;
    assign result_we_o = !is_cmp_d;
    assign flags_nxt_o = state_d.flags;
    assign flags_o     = state_q.flags;

    a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN)) |-> !result_we_o);

    a_r6_cmp_loads_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN))
        |=> (flags_o == $past(flags_nxt_o)));

    a_r7_hold_without_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags_i && op_i[3:2] != 2'b10) |=> $stable(flags_o));

    a_r8_n_z_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_nxt_o[3] && flags_nxt_o[2] && flags_nxt_o != flags_o));

    a_r9_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_SUB && set_flags_i) || op == OP_CMP) |-> (flags_nxt_o[1] == (a_i >= b_i)));

    a_r10_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_AND) || (op == OP_EOR) || (op == OP_ORR) || (op == OP_BIC) ||
         (op == OP_MOV) || (op == OP_MVN) || (op == OP_TST) || (op == OP_TEQ))
        |-> (flags_nxt_o[1:0] == flags_o[1:0]));

endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    op;
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic          sf;
    logic [W-1:0]  result_o;
    logic          result_we_o;
    logic [3:0]    flags_nxt_o;
    logic [3:0]    flags_o;

    int            n_chk  = 0;
    int            n_fail = 0;
    logic [3:0]    mfl;

    always #5 clk = ~clk;

    dp_alu #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .a_i         (a),
        .b_i         (b),
        .set_flags_i (sf),
        .result_o    (result_o),
        .result_we_o (result_we_o),
        .flags_nxt_o (flags_nxt_o),
        .flags_o     (flags_o)
    );

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'hD, 4'hF:             return "R2";
            4'h2, 4'h3, 4'h4:       return "R3";
            4'h5, 4'h6, 4'h7:       return "R4";
            4'h0, 4'h1, 4'hC, 4'hE: return "R5";
            default:                return "R6";
        endcase
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Reference: exact integer arithmetic, flags from range tests.
    task automatic model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic s, input logic [3:0] fl,
                         output logic [W-1:0] r, output logic we, output logic [3:0] nf);
        longint ux = longint'(x);
        longint uy = longint'(y);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint ci = longint'(fl[1]);
        longint u  = 0;
        longint sg = 0;
        logic   c  = fl[1];
        logic   v  = fl[0];
        int     kind = 0; // 0 bitwise, 1 add, 2 subtract
        r = '0;
        case (o)
            4'h0, 4'h8: r = x & y;
            4'h1, 4'h9: r = x ^ y;
            4'hC:       r = x | y;
            4'hE:       r = x & ~y;
            4'hD:       r = y;
            4'hF:       r = ~y;
            4'h4, 4'hB: begin kind = 1; u = ux + uy;          sg = sx + sy;          end
            4'h5:       begin kind = 1; u = ux + uy + ci;     sg = sx + sy + ci;     end
            4'h2, 4'hA: begin kind = 2; u = ux - uy;          sg = sx - sy;          end
            4'h6:       begin kind = 2; u = ux - uy + ci - 1; sg = sx - sy + ci - 1; end
            4'h3:       begin kind = 2; u = uy - ux;          sg = sy - sx;          end
            default:    begin kind = 2; u = uy - ux + ci - 1; sg = sy - sx + ci - 1; end
        endcase
        if (kind != 0) begin
            r = u[W-1:0];
            c = (kind == 1) ? (u >= 64'sh1_0000_0000) : (u >= 0);
            v = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
        end
        we = !(o inside {4'h8, 4'h9, 4'hA, 4'hB});
        nf = (!we || s) ? {r[W-1], (r == '0), c, v} : fl;
    endtask

    task automatic step(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic s);
        logic [W-1:0] er;
        logic         ew;
        logic [3:0]   ef;
        string        t;
        t = tag(o);
        @(negedge clk);
        op = o; a = x; b = y; sf = s;
        model(o, x, y, s, mfl, er, ew, ef);
        #2;
        if (ew) chk(t, result_o, er, "result");
        chk(t, result_we_o, ew, "write enable");
        chk(t, flags_nxt_o, ef, "next flags (R8 R9 R10)");
        @(posedge clk);
        #1;
        mfl = ef;
        chk("R7", flags_o, mfl, "stored flags");
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op = 4'h0; a = '0; b = '0; sf = 1'b0; mfl = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", flags_o, 4'h0, "flags in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", flags_o, 4'h0, "flags after reset");

        // R2 copy and copy-inverted
        step(4'hD, 32'h1234_5678, 32'h9C3E_0A51, 1'b1);
        step(4'hF, 32'h0, 32'h9C3E_0A51, 1'b1);
        // R5 bitwise with a shared pattern
        step(4'h0, 32'hA5C3_0FF0, 32'h3C3C_FF00, 1'b0);
        step(4'h1, 32'hA5C3_0FF0, 32'h3C3C_FF00, 1'b0);
        step(4'hC, 32'hA5C3_0FF0, 32'h3C3C_FF00, 1'b0);
        step(4'hE, 32'hA5C3_0FF0, 32'hFFFF_0000, 1'b0);
        // R8 R9: wrap to zero sets Z and C
        step(4'h4, 32'hFFFF_FFFF, 32'h1, 1'b1);
        // R10: signed overflow on add
        step(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b1);
        // R10: bitwise with set keeps C and V
        step(4'h1, 32'h8000_0000, 32'h0, 1'b1);
        // R6: test-equal leaves V, updates with set low
        step(4'h9, 32'h5, 32'h5, 1'b0);
        // R9: subtract equal -> no borrow, smaller-minus-larger -> borrow
        step(4'h2, 32'd5, 32'd5, 1'b1);
        step(4'h2, 32'd3, 32'd5, 1'b1);
        step(4'h3, 32'd3, 32'd5, 1'b1);
        // R4: 64-bit add chained over two words
        step(4'h4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
        step(4'h5, 32'h0000_0010, 32'h0000_0020, 1'b1);
        // R4: 64-bit subtract with borrow across words
        step(4'h2, 32'h0000_0000, 32'h0000_0001, 1'b1);
        step(4'h6, 32'h0000_0005, 32'h0000_0002, 1'b1);
        step(4'h7, 32'h0000_0002, 32'h0000_0009, 1'b1);
        // R6: compares and tests, set-flags low
        step(4'hA, 32'd7, 32'd9, 1'b0);
        step(4'hB, 32'hFFFF_FFFF, 32'h1, 1'b0);
        step(4'h8, 32'hF0F0_0000, 32'h0F0F_FFFF, 1'b0);
        // R7: arithmetic with set-flags low leaves flags held
        step(4'h4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        step(4'h2, 32'h0, 32'h0, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] rx;
            logic [W-1:0] ry;
            rx = $urandom();
            ry = $urandom();
            if (($urandom() % 8) == 0) rx = ry;
            if (($urandom() % 8) == 1) ry = 32'h8000_0000;
            step(4'($urandom()), rx, ry, 1'($urandom()));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule